// File: doc/BRIEF.md
# Word-Granular Snooping Coherence Controller

This block manages coherence for a small direct-mapped, write-back data cache that sits on a shared snooping bus. Each line holds a tag, a block state (invalid, shared or exclusive) and one valid bit per word. When another cache announces a write miss, it sends a word mask with it. The controller then clears only the valid bits of those words. The remaining words stay readable, even though the block state drops to invalid.

The CPU side presents a read or write request with a block address and a word-select mask. It holds the request until `cpuDone` is high. Hits finish in the cycle they are presented. Misses put commands on the bus output, and memory is treated as a responder that is always ready. Snooped read misses and write misses from other caches arrive on the snoop input. When this cache holds the snooped block exclusive, it answers in the same cycle with a write-back.

Top module: `word_snoop_ctl`

## Requirements
- R1: After reset every line is invalid with no valid words, `cpuDone`, `cpuBusy` and `busValid` are low, and the first read of any address misses.
- R2: A CPU read hits when the addressed line's tag matches and every word selected by `cpuWordMask` is valid. `cpuDone` rises in the same cycle, with no bus command.
- R3: A CPU read that is not a hit and needs no write-back drives a read miss one cycle after the request, carrying the request's block address and word mask. `cpuDone` is high in that same cycle. The line then holds the new tag, all words valid, in the shared state.
- R4: A CPU write to a line with a matching tag in the exclusive state finishes in the request cycle with no bus command.
- R5: Any other CPU write drives a write miss one cycle after the request, carrying the written-word mask. When it is granted, the line takes the new tag, all words valid, in the exclusive state.
- R6: A miss whose line is exclusive under a different tag first drives a write-back. That write-back appears one cycle after the request, with the victim's block address and mask 4'b1111. The miss follows one cycle later, together with `cpuDone`.
- R7: A snooped read miss that matches an exclusive line drives a write-back of the snooped block in the same cycle and makes the line shared. A later CPU write then needs a write miss. A matching snooped read miss to a shared line causes no bus traffic.
- R8: A snooped write miss that matches a line clears only the masked word valid bits and makes the block state invalid. If the line was exclusive, a write-back of that block is driven in the same cycle. CPU reads of words that are still valid continue to hit; reads of cleared words miss.
- R9: A snooped command whose tag differs from the resident line's tag causes no bus command and leaves the line unchanged.
- R10: In any cycle with `snoopValid` high, the snoop is handled first. A pending CPU request does not progress and `cpuDone` stays low.
- R11: Bus and snoop commands use the encoding 1 = read miss, 2 = write miss, 3 = write-back. The block address is {tag, line index}, with the line index in the low 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuRead | input | 1 | CPU read request, held until done |
| cpuWrite | input | 1 | CPU write request, held until done |
| cpuBlockAddr | input | 8 | CPU block address {tag, index} |
| cpuWordMask | input | 4 | Words read or written |
| cpuDone | output | 1 | Request completes this cycle |
| cpuBusy | output | 1 | A miss sequence is outstanding |
| snoopValid | input | 1 | Snooped command present |
| snoopCmd | input | 2 | Snooped command code |
| snoopBlockAddr | input | 8 | Snooped block address |
| snoopMask | input | 4 | Words written by the remote writer |
| busValid | output | 1 | Bus command present |
| busCmd | output | 2 | Bus command code |
| busBlockAddr | output | 8 | Bus block address |
| busMask | output | 4 | Bus word mask |

## Verification
Hits and snoop write-backs are due in the same cycle as their stimulus. A miss is due one cycle later, or two cycles later when a write-back must go first. The bench drives each request just after a falling edge and samples 1 ns later. It then steps one falling edge at a time, so the cycle count at which `cpuDone` appears is the measured latency. Every bus command observed along the way is compared with the expected command, address and mask. Line state is read back only through later requests: a hit or a miss, the presence or absence of a write-back, and the latency together reveal it.

// File: rtl/snpcc_pkg.sv
package snpcc_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } busCmd_t;

  // strobes from control to the line store
  typedef struct packed {
    logic fillEn;    // load requested line with all words valid
    logic fillExcl;  // fill enters exclusive rather than shared
    logic snpClr;    // clear masked words, drop to invalid
    logic snpShare;  // downgrade snooped line to shared
  } lineStrb_t;

endpackage

// File: rtl/snpcc_lines.sv
module snpcc_lines
  import snpcc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int TAG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineStrb_t        strb,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic [TAG_W-1:0] cpuTag,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [IDX_W-1:0] snpIdx,
  input  logic [TAG_W-1:0] snpTag,
  input  logic [WORDS-1:0] snpMask,
  output logic             cpuTagHit,
  output logic [TAG_W-1:0] residentTag,
  output logic [WORDS-1:0] cpuValid,
  output lineState_t       cpuState,
  output logic             snpTagHit,
  output lineState_t       snpState
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tagArr [LINES];
  logic [WORDS-1:0] vldArr [LINES];
  lineState_t       stArr  [LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagArr[i] <= '0;
        vldArr[i] <= '0;
        stArr[i]  <= LS_INV;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strb.fillEn && fillIdx == IDX_W'(i)) begin
          tagArr[i] <= fillTag;
          vldArr[i] <= '1;
          stArr[i]  <= strb.fillExcl ? LS_EXC : LS_SHD;
        end else if (strb.snpClr && snpIdx == IDX_W'(i)) begin
          vldArr[i] <= vldArr[i] & ~snpMask;
          stArr[i]  <= LS_INV;
        end else if (strb.snpShare && snpIdx == IDX_W'(i)) begin
          stArr[i]  <= LS_SHD;
        end
      end
    end
  end

  assign residentTag = tagArr[cpuIdx];
  assign cpuTagHit   = (tagArr[cpuIdx] == cpuTag);
  assign cpuValid    = vldArr[cpuIdx];
  assign cpuState    = stArr[cpuIdx];
  assign snpTagHit   = (tagArr[snpIdx] == snpTag);
  assign snpState    = stArr[snpIdx];

endmodule

// File: rtl/snpcc_ctrl.sv
module snpcc_ctrl
  import snpcc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int TAG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuRead,
  input  logic                   cpuWrite,
  input  logic [IDX_W-1:0]       cpuIdx,
  input  logic [TAG_W-1:0]       cpuTag,
  input  logic [WORDS-1:0]       cpuWordMask,
  input  logic                   snoopValid,
  input  logic [1:0]             snoopCmd,
  input  logic [TAG_W+IDX_W-1:0] snoopBlockAddr,
  input  logic                   cpuTagHit,
  input  logic [TAG_W-1:0]       residentTag,
  input  logic [WORDS-1:0]       cpuValid,
  input  lineState_t             cpuState,
  input  logic                   snpTagHit,
  input  lineState_t             snpState,
  output lineStrb_t              strb,
  output logic [IDX_W-1:0]       reqIdx,
  output logic [TAG_W-1:0]       reqTag,
  output logic                   cpuDone,
  output logic                   cpuBusy,
  output logic                   busValid,
  output logic [1:0]             busCmd,
  output logic [TAG_W+IDX_W-1:0] busBlockAddr,
  output logic [WORDS-1:0]       busMask
);
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_MISS} fsm_t;

  fsm_t             fsm, fsmNext;
  logic [WORDS-1:0] reqMask;
  logic             reqWrite;
  logic [TAG_W-1:0] victimTag;
  logic             capture;
  logic             cpuHit;

  assign cpuHit = cpuTagHit &&
                  (cpuWrite ? (cpuState == LS_EXC)
                            : ((cpuValid & cpuWordMask) == cpuWordMask));

  always_comb begin
    strb         = '0;
    cpuDone      = 1'b0;
    capture      = 1'b0;
    fsmNext      = fsm;
    busValid     = 1'b0;
    busCmd       = BC_NONE;
    busBlockAddr = '0;
    busMask      = '0;
    if (snoopValid) begin
      // snoop owns this cycle; the CPU side holds still
      if (snpTagHit && snoopCmd == BC_RDMISS && snpState == LS_EXC) begin
        strb.snpShare = 1'b1;
        busValid      = 1'b1;
        busCmd        = BC_WRBACK;
        busBlockAddr  = snoopBlockAddr;
        busMask       = '1;
      end else if (snpTagHit && snoopCmd == BC_WRMISS) begin
        strb.snpClr = 1'b1;
        if (snpState == LS_EXC) begin
          busValid     = 1'b1;
          busCmd       = BC_WRBACK;
          busBlockAddr = snoopBlockAddr;
          busMask      = '1;
        end
      end
    end else begin
      unique case (fsm)
        ST_IDLE: begin
          if (cpuRead || cpuWrite) begin
            if (cpuHit) begin
              cpuDone = 1'b1;
            end else begin
              capture = 1'b1;
              fsmNext = (cpuState == LS_EXC && !cpuTagHit) ? ST_WBACK : ST_MISS;
            end
          end
        end
        ST_WBACK: begin
          busValid     = 1'b1;
          busCmd       = BC_WRBACK;
          busBlockAddr = {victimTag, reqIdx};
          busMask      = '1;
          fsmNext      = ST_MISS;
        end
        ST_MISS: begin
          busValid      = 1'b1;
          busCmd        = reqWrite ? BC_WRMISS : BC_RDMISS;
          busBlockAddr  = {reqTag, reqIdx};
          busMask       = reqMask;
          strb.fillEn   = 1'b1;
          strb.fillExcl = reqWrite;
          cpuDone       = 1'b1;
          fsmNext       = ST_IDLE;
        end
        default: fsmNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm       <= ST_IDLE;
      reqIdx    <= '0;
      reqTag    <= '0;
      reqMask   <= '0;
      reqWrite  <= 1'b0;
      victimTag <= '0;
    end else begin
      fsm <= fsmNext;
      if (capture) begin
        reqIdx    <= cpuIdx;
        reqTag    <= cpuTag;
        reqMask   <= cpuWordMask;
        reqWrite  <= cpuWrite;
        victimTag <= residentTag;
      end
    end
  end

  assign cpuBusy = (fsm != ST_IDLE);

endmodule

// File: rtl/word_snoop_ctl.sv
module word_snoop_ctl
  import snpcc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int TAG_W = 6,
  parameter int IDX_W = 2,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuBlockAddr,
  input  logic [WORDS-1:0]  cpuWordMask,
  output logic              cpuDone,
  output logic              cpuBusy,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopBlockAddr,
  input  logic [WORDS-1:0]  snoopMask,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busBlockAddr,
  output logic [WORDS-1:0]  busMask
);
  lineStrb_t        strb;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic             cpuTagHit, snpTagHit;
  logic [TAG_W-1:0] residentTag;
  logic [WORDS-1:0] cpuValid;
  lineState_t       cpuState, snpState;

  snpcc_lines #(.WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lines (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuIdx     (cpuBlockAddr[IDX_W-1:0]),
    .cpuTag     (cpuBlockAddr[ADDR_W-1:IDX_W]),
    .fillIdx    (reqIdx),
    .fillTag    (reqTag),
    .snpIdx     (snoopBlockAddr[IDX_W-1:0]),
    .snpTag     (snoopBlockAddr[ADDR_W-1:IDX_W]),
    .snpMask    (snoopMask),
    .cpuTagHit  (cpuTagHit),
    .residentTag(residentTag),
    .cpuValid   (cpuValid),
    .cpuState   (cpuState),
    .snpTagHit  (snpTagHit),
    .snpState   (snpState)
  );

  snpcc_ctrl #(.WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cpuRead       (cpuRead),
    .cpuWrite      (cpuWrite),
    .cpuIdx        (cpuBlockAddr[IDX_W-1:0]),
    .cpuTag        (cpuBlockAddr[ADDR_W-1:IDX_W]),
    .cpuWordMask   (cpuWordMask),
    .snoopValid    (snoopValid),
    .snoopCmd      (snoopCmd),
    .snoopBlockAddr(snoopBlockAddr),
    .cpuTagHit     (cpuTagHit),
    .residentTag   (residentTag),
    .cpuValid      (cpuValid),
    .cpuState      (cpuState),
    .snpTagHit     (snpTagHit),
    .snpState      (snpState),
    .strb          (strb),
    .reqIdx        (reqIdx),
    .reqTag        (reqTag),
    .cpuDone       (cpuDone),
    .cpuBusy       (cpuBusy),
    .busValid      (busValid),
    .busCmd        (busCmd),
    .busBlockAddr  (busBlockAddr),
    .busMask       (busMask)
  );

endmodule

// File: rtl/word_snoop_ctl_chk.sv
module word_snoop_ctl_chk #(
  parameter int WORDS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuDone,
  input logic             cpuBusy,
  input logic             snoopValid,
  input logic             busValid,
  input logic [1:0]       busCmd,
  input logic [WORDS-1:0] busMask
);
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> !cpuDone);

  p_miss_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (busCmd == 2'd1 || busCmd == 2'd2)) |-> (cpuDone && cpuBusy));

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuBusy) |=> !cpuBusy);

  p_wb_then_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busCmd == 2'd3 && !snoopValid) |=>
      (snoopValid || (busValid && busCmd != 2'd3)));

  p_wb_full_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busCmd == 2'd3) |-> (busMask == {WORDS{1'b1}}));

  p_bus_has_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (snoopValid || cpuBusy));

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && !cpuBusy) |-> !busValid);

  p_cmd_known_r11: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busCmd != 2'd0));

endmodule

bind word_snoop_ctl word_snoop_ctl_chk #(.WORDS(WORDS)) u_chk (.*);

// File: tb/word_snoop_ctl_tb.sv
module word_snoop_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuRead = 1'b0, cpuWrite = 1'b0;
  logic [7:0] cpuBlockAddr = '0;
  logic [3:0] cpuWordMask = '0;
  logic       cpuDone, cpuBusy;
  logic       snoopValid = 1'b0;
  logic [1:0] snoopCmd = '0;
  logic [7:0] snoopBlockAddr = '0;
  logic [3:0] snoopMask = '0;
  logic       busValid;
  logic [1:0] busCmd;
  logic [7:0] busBlockAddr;
  logic [3:0] busMask;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  word_snoop_ctl u_dut (.*);

  // op: 0 cpu read, 1 cpu write, 2 snooped read miss, 3 snooped write miss
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [3:0] mask;
    logic [1:0] lat;
    logic       wb;
    logic [1:0] miss;
    logic [7:0] vaddr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h04, 4'b0001, 2'd1, 1'b0, 2'd1, 8'h00, 4'd1},  // R1 first read misses
    '{2'd0, 8'h04, 4'b1111, 2'd0, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 hit
    '{2'd2, 8'h04, 4'b0000, 2'd0, 1'b0, 2'd0, 8'h00, 4'd7},  // R7 shared: no write-back
    '{2'd1, 8'h04, 4'b0010, 2'd1, 1'b0, 2'd2, 8'h00, 4'd5},  // R5 shared -> exclusive
    '{2'd1, 8'h04, 4'b0100, 2'd0, 1'b0, 2'd0, 8'h00, 4'd4},  // R4 exclusive write hit
    '{2'd0, 8'h04, 4'b1000, 2'd0, 1'b0, 2'd0, 8'h00, 4'd2},  // R2
    '{2'd2, 8'h04, 4'b0000, 2'd0, 1'b1, 2'd0, 8'h04, 4'd7},  // R7 write-back, to shared
    '{2'd1, 8'h04, 4'b0001, 2'd1, 1'b0, 2'd2, 8'h00, 4'd7},  // R7 write now misses
    '{2'd3, 8'h04, 4'b0011, 2'd0, 1'b1, 2'd0, 8'h04, 4'd8},  // R8 exclusive: write-back
    '{2'd0, 8'h04, 4'b1100, 2'd0, 1'b0, 2'd0, 8'h00, 4'd8},  // R8 survivors hit
    '{2'd0, 8'h04, 4'b0001, 2'd1, 1'b0, 2'd1, 8'h00, 4'd8},  // R8 cleared word misses
    '{2'd3, 8'h04, 4'b0100, 2'd0, 1'b0, 2'd0, 8'h00, 4'd8},  // R8 shared: no write-back
    '{2'd0, 8'h04, 4'b1011, 2'd0, 1'b0, 2'd0, 8'h00, 4'd8},  // R8
    '{2'd0, 8'h04, 4'b0100, 2'd1, 1'b0, 2'd1, 8'h00, 4'd3},  // R3 refill
    '{2'd3, 8'h08, 4'b1111, 2'd0, 1'b0, 2'd0, 8'h00, 4'd9},  // R9 other tag
    '{2'd0, 8'h04, 4'b1111, 2'd0, 1'b0, 2'd0, 8'h00, 4'd9},  // R9 line untouched
    '{2'd1, 8'h04, 4'b1111, 2'd1, 1'b0, 2'd2, 8'h00, 4'd5},  // R5
    '{2'd0, 8'h08, 4'b0010, 2'd2, 1'b1, 2'd1, 8'h04, 4'd6},  // R6 evict exclusive
    '{2'd0, 8'h04, 4'b0001, 2'd1, 1'b0, 2'd1, 8'h00, 4'd3},  // R3 tag mismatch, shared victim
    '{2'd1, 8'h05, 4'b1000, 2'd1, 1'b0, 2'd2, 8'h00, 4'd5},  // R5 line 1
    '{2'd1, 8'h09, 4'b0001, 2'd2, 1'b1, 2'd2, 8'h05, 4'd6},  // R6 write evicts exclusive
    '{2'd2, 8'h05, 4'b0000, 2'd0, 1'b0, 2'd0, 8'h00, 4'd9},  // R9
    '{2'd2, 8'h09, 4'b0000, 2'd0, 1'b1, 2'd0, 8'h09, 4'd7},  // R7
    '{2'd1, 8'h09, 4'b0001, 2'd1, 1'b0, 2'd2, 8'h00, 4'd7}   // R7
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cpuOp(input vec_t v);
    int  lat = 0;
    bit  sawWb = 0;
    int  sawMiss = 0;
    @(negedge clk);
    cpuRead = (v.op == 2'd0);
    cpuWrite = (v.op == 2'd1);
    cpuBlockAddr = v.addr;
    cpuWordMask = v.mask;
    forever begin
      #1;
      if (busValid && busCmd == 2'd3) begin
        sawWb = 1;
        chk(busBlockAddr == v.vaddr && busMask == 4'hF, int'(v.req),
            "write-back address/mask (R11)", int'({busBlockAddr, busMask}),
            int'({v.vaddr, 4'hF}));
      end else if (busValid) begin
        sawMiss = int'(busCmd);
        chk(busBlockAddr == v.addr && busMask == v.mask, int'(v.req),
            "miss address/mask (R11)", int'({busBlockAddr, busMask}),
            int'({v.addr, v.mask}));
      end
      if (cpuDone || lat > 6) break;
      lat++;
      @(negedge clk);
      #0;
    end
    chk(lat == int'(v.lat), int'(v.req), "latency", lat, int'(v.lat));
    chk(sawWb == v.wb, int'(v.req), "write-back seen", int'(sawWb), int'(v.wb));
    chk(sawMiss == int'(v.miss), int'(v.req), "miss command (R11)", sawMiss, int'(v.miss));
    @(negedge clk);
    cpuRead = 0;
    cpuWrite = 0;
  endtask

  task automatic snpOp(input vec_t v);
    @(negedge clk);
    snoopValid = 1;
    snoopCmd = (v.op == 2'd2) ? 2'd1 : 2'd2;
    snoopBlockAddr = v.addr;
    snoopMask = v.mask;
    #1;
    chk((busValid && busCmd == 2'd3) == v.wb, int'(v.req), "snoop write-back",
        int'(busValid && busCmd == 2'd3), int'(v.wb));
    if (v.wb)
      chk(busBlockAddr == v.addr && busMask == 4'hF, int'(v.req),
          "snoop write-back address", int'(busBlockAddr), int'(v.addr));
    @(negedge clk);
    snoopValid = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    chk(!busValid && !cpuDone && !cpuBusy, 1, "outputs in reset R1",
        int'({busValid, cpuDone, cpuBusy}), 0);
    rstN = 1;
    @(negedge clk);
    #1;
    chk(!busValid && !cpuDone && !cpuBusy, 1, "outputs after reset R1",
        int'({busValid, cpuDone, cpuBusy}), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op < 2'd2) cpuOp(VECS[i]);
      else snpOp(VECS[i]);
    end

    // R10: a hit presented with an unrelated snoop waits one cycle
    @(negedge clk);
    cpuRead = 1;
    cpuBlockAddr = 8'h04;
    cpuWordMask = 4'b0001;
    snoopValid = 1;
    snoopCmd = 2'd2;
    snoopBlockAddr = 8'h0C;
    snoopMask = 4'hF;
    #1;
    chk(!cpuDone && !busValid, 10, "done during snoop R10", int'(cpuDone), 0);
    @(negedge clk);
    snoopValid = 0;
    #1;
    chk(cpuDone && !busValid, 10, "done after snoop R10", int'(cpuDone), 1);
    @(negedge clk);
    cpuRead = 0;

    // R10: a miss held back by a snoop, then completes
    @(negedge clk);
    cpuRead = 1;
    cpuBlockAddr = 8'h0C;
    cpuWordMask = 4'b0010;
    #1;
    chk(!cpuDone, 10, "miss request cycle R10", int'(cpuDone), 0);
    @(negedge clk);
    snoopValid = 1;
    snoopCmd = 2'd1;
    snoopBlockAddr = 8'h10;
    #1;
    chk(!cpuDone && !busValid, 10, "miss stalled by snoop R10",
        int'({cpuDone, busValid}), 0);
    @(negedge clk);
    snoopValid = 0;
    #1;
    chk(cpuDone && busValid && busCmd == 2'd1 && busBlockAddr == 8'h0C, 10,
        "miss resumes R10", int'(busCmd), 1);
    @(negedge clk);
    cpuRead = 0;

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule